// File: doc/BRIEF.md
# Warm Reset Sequencer

This controller watches a shared, active-low, open-drain reset line. When an outside agent pulls that line low, the controller runs a fixed warm reset sequence.

1. It joins in holding the line low.
2. It releases the memory data bus to high impedance.
3. It forces the memory control strobes inactive.
4. It keeps the address bus driven at all ones.

After a first timed window the controller stops pulling the line. It then needs two things before it drives the data bus again: a second full window must have passed since its own release, and the line must be sampled high through the synchronizer. After that, a short guard interval keeps the first chip-select blocked. When the guard ends, a one-cycle request is sent to the core to take its soft reset exception.

The line is modelled as an output-enable that pulls the net low plus a sampled input. The input passes through a synchronizer before the controller uses it. An asynchronous active-low cold reset returns the controller to idle and clears its counters. The window length and guard length are parameters, so short values can be used in simulation.

Top module: `wrst_seq`

## Requirements
- R1: With the controller idle, a low level on `rst_line_i` starts the sequence. `busy_o` and the other sequence outputs change three clock edges after the input falls: two synchronizer stages plus the state register.
- R2: From sequence start until resume, `data_oe` is 0 (data bus high impedance) and `ctrl_o` is all zeros (strobes inactive, where 1 means active).
- R3: While `data_oe` is 0 during a sequence, `addr_o` is all ones.
- R4: `rst_line_oe` is 1 for exactly `WIN_CYCLES` cycles, starting in the first cycle of the sequence.
- R5: Resume (`data_oe` returning to 1) happens no earlier than `WIN_CYCLES` cycles after `rst_line_oe` falls.
- R6: Resume requires the line to be sampled high. If the line is still low when the second window ends, the controller keeps waiting. It then resumes three edges after the line goes high at the pin.
- R7: `cs0_o` stays 0 from sequence start until `GUARD_CYCLES` cycles after resume.
- R8: `busy_o` is 1 from sequence start through the last guard cycle. `exc_o` is a single-cycle pulse in the first cycle after the guard.
- R9: A low `cold_rst_n` immediately forces the idle outputs and clears the counters. A sequence started afterwards has full-length windows.
- R10: When idle, `addr_o` = `addr_i`, `ctrl_o` = `ctrl_i`, `cs0_o` = `cs0_req_i`, `data_oe` = 1, and `rst_line_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| rst_line_i | input | 1 | Sampled level of the shared reset line (0 = asserted) |
| rst_line_oe | output | 1 | 1 pulls the shared reset line low |
| addr_i | input | ADDR_W | Address from the memory controller |
| ctrl_i | input | CTRL_W | Control strobes from the memory controller (1 = active) |
| cs0_req_i | input | 1 | First chip-select request (1 = active) |
| addr_o | output | ADDR_W | Address to the pins |
| ctrl_o | output | CTRL_W | Gated control strobes |
| cs0_o | output | 1 | Gated first chip-select |
| data_oe | output | 1 | Data bus output enable (0 = high impedance) |
| busy_o | output | 1 | Sequence in progress |
| exc_o | output | 1 | One-cycle soft reset exception request to the core |

## Verification
The hardest case to reach from the ports is the late release, where the line is still held low when the second window expires. The controller must then keep waiting past its own count. The stimulus reaches it by drawing the outside agent's release time at random over a range wider than twice the window. Directed runs add a release that lands exactly at the window boundary, a release that comes very late, and a one-cycle request pulse. Every output is compared each cycle against an expected value computed from the release time. A cold reset in the middle of the hold window is followed by a fresh sequence, which shows that the counters really restart.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GUARD = 2'd3
    } wrs_state_e;
endpackage

// File: rtl/wrs_sync.sv
module wrs_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) sh_q <= RESET_VAL;
                else         sh_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) sh_q <= {STAGES{RESET_VAL}};
                else         sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wrs_gate.sv
module wrs_gate
    import wrs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 4
) (
    input  wrs_state_e        st,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              cs0_req_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              cs0_o,
    output logic              data_oe
);
    logic bus_parked;
    logic cs0_block;

    always_comb begin
        bus_parked = (st == ST_HOLD) || (st == ST_WAIT);
        cs0_block  = bus_parked || (st == ST_GUARD);
        data_oe    = !bus_parked;
        addr_o     = bus_parked ? {ADDR_W{1'b1}} : addr_i;
        ctrl_o     = bus_parked ? '0 : ctrl_i;
        cs0_o      = cs0_block ? 1'b0 : cs0_req_i;
    end
endmodule

// File: rtl/wrst_seq.sv
module wrst_seq
    import wrs_pkg::*;
#(
    parameter int WIN_CYCLES   = 4000,
    parameter int GUARD_CYCLES = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int ADDR_W       = 32,
    parameter int CTRL_W       = 4
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_line_i,
    output logic              rst_line_oe,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              cs0_req_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              cs0_o,
    output logic              data_oe,
    output logic              busy_o,
    output logic              exc_o
);
    localparam int MAX_CNT = (WIN_CYCLES > GUARD_CYCLES) ? WIN_CYCLES : GUARD_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] WIN_M1   = CNT_W'(WIN_CYCLES - 1);
    localparam logic [CNT_W-1:0] GUARD_M1 = CNT_W'(GUARD_CYCLES - 1);

    typedef struct packed {
        wrs_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             exc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic line_s;

    wrs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk    (clk),
        .arst_n (cold_rst_n),
        .d      (rst_line_i),
        .q      (line_s)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.exc = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (!line_s) begin
                    ctl_d.st  = ST_HOLD;
                    ctl_d.cnt = WIN_M1;
                end
            end
            ST_HOLD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_WAIT;
                    ctl_d.cnt = WIN_M1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_WAIT: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else if (line_s) begin
                    ctl_d.st  = ST_GUARD;
                    ctl_d.cnt = GUARD_M1;
                end
            end
            ST_GUARD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.exc = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, exc: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rst_line_oe = (ctl_q.st == ST_HOLD);
    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign exc_o       = ctl_q.exc;

    wrs_gate #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_gate (
        .st        (ctl_q.st),
        .addr_i    (addr_i),
        .ctrl_i    (ctrl_i),
        .cs0_req_i (cs0_req_i),
        .addr_o    (addr_o),
        .ctrl_o    (ctrl_o),
        .cs0_o     (cs0_o),
        .data_oe   (data_oe)
    );

    // Checker state: length of the current pull-low run.
    logic [CNT_W:0] oe_run_q;
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n)      oe_run_q <= '0;
        else if (rst_line_oe) oe_run_q <= oe_run_q + 1'b1;
        else                  oe_run_q <= '0;
    end

    p_oe_window_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $fell(rst_line_oe) |-> (oe_run_q == (CNT_W+1)'(WIN_CYCLES)));

    p_data_hiz_r2: assert property (@(posedge clk) disable iff (!cold_rst_n)
        rst_line_oe |-> (!data_oe && ctrl_o == '0));

    p_addr_ones_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !data_oe |-> (addr_o == {ADDR_W{1'b1}}));

    p_resume_line_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(data_oe) |-> $past(line_s));

    p_cs0_gate_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
        busy_o |-> !cs0_o);

    p_exc_pulse_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        exc_o |=> !exc_o);

    p_exc_idle_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        exc_o |-> !busy_o);
endmodule

// File: tb/wrst_seq_bench.sv
module wrst_seq_bench;
    localparam int W  = 40;
    localparam int G  = 16;
    localparam int AW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          cold_rst_n = 1'b0;
    logic          ext_low = 1'b0;
    logic          rst_line;
    logic          rst_line_oe;
    logic [AW-1:0] addr_i = '0, addr_o;
    logic [CW-1:0] ctrl_i = '0, ctrl_o;
    logic          cs0_req_i = 1'b0, cs0_o, data_oe, busy_o, exc_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    // wired-AND open-drain net
    assign rst_line = ~(ext_low | rst_line_oe);

    wrst_seq #(.WIN_CYCLES(W), .GUARD_CYCLES(G), .SYNC_STAGES(2),
               .ADDR_W(AW), .CTRL_W(CW)) u_wrst_seq (
        .clk(clk), .cold_rst_n(cold_rst_n), .rst_line_i(rst_line),
        .rst_line_oe(rst_line_oe), .addr_i(addr_i), .ctrl_i(ctrl_i),
        .cs0_req_i(cs0_req_i), .addr_o(addr_o), .ctrl_o(ctrl_o),
        .cs0_o(cs0_o), .data_oe(data_oe), .busy_o(busy_o), .exc_o(exc_o)
    );

    task automatic chk(input string req, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic drive_rand();
        addr_i    = $urandom;
        ctrl_i    = CW'($urandom);
        cs0_req_i = 1'($urandom);
    endtask

    task automatic chk_idle(input string req);
        chk(req, "data_oe", 32'(data_oe), 32'd1);
        chk(req, "addr_o", addr_o, addr_i);
        chk(req, "ctrl_o", 32'(ctrl_o), 32'(ctrl_i));
        chk(req, "cs0_o", 32'(cs0_o), 32'(cs0_req_i));
        chk(req, "rst_line_oe", 32'(rst_line_oe), 32'd0);
        chk(req, "busy_o", 32'(busy_o), 32'd0);
        chk(req, "exc_o", 32'(exc_o), 32'd0);
    endtask

    function automatic int resume_at(input int rel);
        int a = 3 + 2 * W;
        int b = rel + 3;
        return (a > b) ? a : b;
    endfunction

    // rel: negedge index at which the outside agent lets go of the line
    task automatic run_seq(input int rel);
        int x = resume_at(rel);
        string dtag;
        for (int n = 0; n <= x + G + 3; n++) begin
            @(negedge clk);
            if (n == 0)   ext_low = 1'b1;
            if (n == rel) ext_low = 1'b0;
            drive_rand();
            #1;
            begin
                bit blk  = (n >= 3) && (n < x);
                bit busy = (n >= 3) && (n < x + G);
                if (n == 3)      dtag = "R1";
                else if (n == x) dtag = (rel + 3 > 3 + 2 * W) ? "R6" : "R5";
                else             dtag = "R2";
                chk(dtag, "data_oe", 32'(data_oe), 32'(!blk));
                chk(blk ? "R2" : "R10", "ctrl_o", 32'(ctrl_o), blk ? 32'd0 : 32'(ctrl_i));
                chk(blk ? "R3" : "R10", "addr_o", addr_o, blk ? 32'hFFFF_FFFF : addr_i);
                chk("R4", "rst_line_oe", 32'(rst_line_oe), 32'((n >= 3) && (n < 3 + W)));
                chk(n == 3 ? "R1" : "R8", "busy_o", 32'(busy_o), 32'(busy));
                chk("R8", "exc_o", 32'(exc_o), 32'(n == x + G));
                chk("R7", "cs0_o", 32'(cs0_o), busy ? 32'd0 : 32'(cs0_req_i));
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        drive_rand();
        #1;
        chk_idle("R10");
        cold_rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            drive_rand();
            #1;
            chk_idle("R10");
        end

        // directed corners
        run_seq(1);             // one-cycle request pulse
        run_seq(2 * W);         // release exactly at the window boundary
        run_seq(3 * W + 7);     // held long past the second window (R6)

        // cold reset in the middle of the hold window (R9)
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (n == 0) ext_low = 1'b1;
            drive_rand();
        end
        #1;
        chk("R9", "rst_line_oe before cold", 32'(rst_line_oe), 32'd1);
        cold_rst_n = 1'b0;
        ext_low    = 1'b0;
        #1;
        chk_idle("R9");
        @(negedge clk);
        cold_rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            drive_rand();
            #1;
            chk_idle("R9");
        end
        run_seq(5);             // full-length windows after cold reset

        // random release times
        for (int k = 0; k < 25; k++) begin
            run_seq(1 + int'($urandom_range(3 * W + 10)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule